// File: doc/BRIEF.md
# Root Port Link-Up Supervisor

This block brings up one root port link and reports the result. A start strobe begins an attempt. The block first waits for the data-link layer to come up, then waits for the link to go active. Time is measured only in externally supplied millisecond ticks. Each wait has its own tick budget. If either wait runs out, the block asserts the port reset for a short tick-counted interval, releases it, and tries again. The number of attempts is bounded.

When the sequence ends, a one-cycle done pulse appears together with a sticky verdict: link good or link failed. The verdict stays unchanged until the next start. One instance serves one port, and two instances side by side are the usual arrangement. Bringing the physical layer up is the job of other logic.

Top module: `link_up_supervisor`

## Requirements
- R1: While rst_ni is low, and after it is released, port_rst_o, done_o, link_ok_o and link_fail_o are all 0 until the first start.
- R2: A start_i sampled in idle begins the data-link wait. If dl_up_i stays low for WAIT_TICKS (default 200) sampled ticks of tick_i, the wait times out, the active wait is skipped, and port_rst_o is raised.
- R3: When dl_up_i is sampled high during the data-link wait, the link-active wait starts with a fresh budget of WAIT_TICKS ticks. A dl_up_i seen after WAIT_TICKS-1 ticks is still accepted.
- R4: When link_act_i is sampled high during the link-active wait, the block finishes in that cycle with link_ok_o set and no further reset pulse. A link_act_i seen after WAIT_TICKS-1 ticks of that wait is still accepted.
- R5: If link_act_i stays low for WAIT_TICKS ticks of the link-active wait, port_rst_o is raised.
- R6: port_rst_o stays high for exactly RST_TICKS (default 1) ticks of tick_i. Each reset pulse ends one attempt. If attempts remain, a new data-link wait starts with a full budget.
- R7: The reset pulse that ends attempt number ATTEMPTS (default 3) finishes the sequence with link_fail_o set. The block therefore gives at most ATTEMPTS reset pulses per run.
- R8: done_o is high for exactly one cycle per run. In that cycle exactly one of link_ok_o and link_fail_o is 1.
- R9: link_ok_o and link_fail_o hold their value after done_o until the next accepted start, which clears both.
- R10: A start_i that arrives while a run is in progress has no effect on the timing, the reset pulses or the result of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a link-up run (one-cycle strobe) |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| dl_up_i | input | 1 | Data-link layer up indication |
| link_act_i | input | 1 | Link active indication |
| port_rst_o | output | 1 | Port reset, high during a retry pulse |
| done_o | output | 1 | One-cycle pulse when the run ends |
| link_ok_o | output | 1 | Run ended with the link active |
| link_fail_o | output | 1 | Run ended after all attempts were used |

## Verification
The hardest cases to reach are at the boundaries of the retry loop. One is a link that fails on early attempts and comes up on a later one. Another is a wait that ends exactly one tick before its budget runs out. The bench reaches these with a link-partner model. The model counts the reset pulses it has seen and uses that count to decide whether the current attempt is stuck in the data-link phase, stuck in the active phase, or succeeds. It raises each indication a set number of ticks after the phase it belongs to begins. Ticks arrive only every third cycle, so the bench can check that the timeout budgets and the pulse length are measured in ticks and not in clock cycles.

// File: rtl/lus_pkg.sv
package lus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_DL,
    ST_WAIT_ACT,
    ST_RST
  } lus_state_e;
endpackage

// File: rtl/lus_timer.sv
module lus_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (load_i)                         cnt_q <= load_val_i;
    else if (en_i && tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = en_i && tick_i && (cnt_q == TW'(1));

  // R6
  cnt_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/lus_attempts.sv
module lus_attempts #(
  parameter int ATTEMPTS = 3,
  parameter int AW = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == AW'(ATTEMPTS - 1));

  // R7
  attempt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < AW'(ATTEMPTS));
endmodule

// File: rtl/lus_ctrl.sv
module lus_ctrl
  import lus_pkg::*;
#(
  parameter int WAIT_TICKS = 200,
  parameter int RST_TICKS  = 1,
  parameter int TW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dl_up_i,
  input  logic          act_i,
  input  logic          expire_i,
  input  logic          last_i,
  output logic          timer_en_o,
  output logic          load_o,
  output logic [TW-1:0] load_val_o,
  output logic          att_clr_o,
  output logic          att_inc_o,
  output logic          port_rst_o,
  output logic          done_o,
  output logic          ok_o,
  output logic          fail_o
);
  lus_state_e state_q, state_d;
  logic done_d, ok_d, fail_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = TW'(WAIT_TICKS);
    att_clr_o  = 1'b0;
    att_inc_o  = 1'b0;
    done_d     = 1'b0;
    ok_d       = ok_o;
    fail_d     = fail_o;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_WAIT_DL;
        load_o    = 1'b1;
        att_clr_o = 1'b1;
        ok_d      = 1'b0;
        fail_d    = 1'b0;
      end
      ST_WAIT_DL: begin
        if (dl_up_i) begin
          state_d = ST_WAIT_ACT;
          load_o  = 1'b1;
        end else if (expire_i) begin
          state_d    = ST_RST;
          load_o     = 1'b1;
          load_val_o = TW'(RST_TICKS);
        end
      end
      ST_WAIT_ACT: begin
        if (act_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          ok_d    = 1'b1;
        end else if (expire_i) begin
          state_d    = ST_RST;
          load_o     = 1'b1;
          load_val_o = TW'(RST_TICKS);
        end
      end
      ST_RST: if (expire_i) begin
        if (last_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          fail_d  = 1'b1;
        end else begin
          state_d   = ST_WAIT_DL;
          load_o    = 1'b1;
          att_inc_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      ok_o    <= 1'b0;
      fail_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      ok_o    <= ok_d;
      fail_o  <= fail_d;
    end
  end

  assign timer_en_o = (state_q != ST_IDLE);
  assign port_rst_o = (state_q == ST_RST);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  result_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ok_o ^ fail_o));
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> ($stable(ok_o) && $stable(fail_o)));
  // R7
  fail_after_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(port_rst_o));
  // R4
  ok_from_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> ($past(act_i) && !port_rst_o));
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_DL && start_i && !dl_up_i && !expire_i) |=> (state_q == ST_WAIT_DL));
endmodule

// File: rtl/link_up_supervisor.sv
module link_up_supervisor #(
  parameter int WAIT_TICKS = 200,
  parameter int RST_TICKS  = 1,
  parameter int ATTEMPTS   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  input  logic dl_up_i,
  input  logic link_act_i,
  output logic port_rst_o,
  output logic done_o,
  output logic link_ok_o,
  output logic link_fail_o
);
  localparam int MAX_TICKS = (WAIT_TICKS > RST_TICKS) ? WAIT_TICKS : RST_TICKS;
  localparam int TW = $clog2(MAX_TICKS + 1);
  localparam int AW = (ATTEMPTS > 1) ? $clog2(ATTEMPTS) : 1;

  logic          timer_en, load, expire, att_clr, att_inc, last;
  logic [TW-1:0] load_val;

  lus_ctrl #(.WAIT_TICKS(WAIT_TICKS), .RST_TICKS(RST_TICKS), .TW(TW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .dl_up_i, .act_i(link_act_i),
    .expire_i(expire), .last_i(last),
    .timer_en_o(timer_en), .load_o(load), .load_val_o(load_val),
    .att_clr_o(att_clr), .att_inc_o(att_inc),
    .port_rst_o, .done_o, .ok_o(link_ok_o), .fail_o(link_fail_o)
  );

  lus_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni, .en_i(timer_en), .load_i(load), .load_val_i(load_val),
    .tick_i, .expire_o(expire)
  );

  lus_attempts #(.ATTEMPTS(ATTEMPTS), .AW(AW)) u_att (
    .clk_i, .rst_ni, .clr_i(att_clr), .inc_i(att_inc), .last_o(last)
  );
endmodule

// File: tb/sim_link_up_supervisor.sv
`timescale 1ns/1ps
module sim_link_up_supervisor;
  typedef struct packed {
    int fail_att;  // attempts the partner model keeps stuck
    int stuck_act; // 0: stuck before data-link up, 1: stuck before active
    int dl_lat;    // ticks into an attempt until dl_up rises (>=1)
    int act_lat;   // ticks of active wait until link_act rises
    int inj;       // inject start while busy
    int exp_ok;
    int exp_pulses;
    int exp_waits;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{0, 0,   1,   1, 0, 1, 0,   2},
    '{0, 0, 199, 199, 0, 1, 0, 398},
    '{0, 0, 200,   1, 0, 0, 3, 600},
    '{0, 0,   5, 200, 0, 0, 3, 615},
    '{1, 0,   3,   4, 1, 1, 1, 207},
    '{2, 1,  10,  20, 0, 1, 2, 450},
    '{3, 0,   1,   1, 1, 0, 3, 600}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, tick_i = 1'b0, dl_up_i = 1'b0, link_act_i = 1'b0;
  logic port_rst_o, done_o, link_ok_o, link_fail_o;

  int checks = 0, fails = 0, cyc = 0;
  bit run_on = 0, rst_prev = 0, dl_q = 0;
  int pulses, rst_ticks, wait_ticks, att_ticks, act_cnt, done_cnt;
  int m_fail_att, m_stuck_act, m_dl_lat, m_act_lat;

  always #2.5 clk = ~clk;

  link_up_supervisor u0 (
    .clk_i(clk), .rst_ni, .start_i, .tick_i, .dl_up_i, .link_act_i,
    .port_rst_o, .done_o, .link_ok_o, .link_fail_o
  );

  // monitor at the active edge: reads pre-edge values
  always @(posedge clk) begin
    if (done_o) done_cnt++;
    if (run_on) begin
      if (done_o) run_on = 0;
      else if (port_rst_o) begin
        if (!rst_prev) pulses++;
        if (tick_i) rst_ticks++;
        att_ticks = 0; act_cnt = 0; dl_q = 0;
      end else begin
        if (tick_i) begin
          wait_ticks++; att_ticks++;
          if (dl_up_i && dl_q) act_cnt++;
        end
        dl_q = dl_up_i;
      end
    end
    rst_prev = port_rst_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    bit good, dl;
    @(negedge clk);
    cyc++;
    tick_i = (cyc % 3 == 0);
    good = (pulses >= m_fail_att);
    dl = run_on && !port_rst_o && (good || m_stuck_act != 0) && att_ticks >= m_dl_lat;
    dl_up_i = dl;
    link_act_i = dl && good && act_cnt >= m_act_lat;
  endtask

  task automatic run(input vec_t v, input int idx);
    int k;
    bit hold_ok, hold_fail;
    m_fail_att = v.fail_att; m_stuck_act = v.stuck_act;
    m_dl_lat = v.dl_lat; m_act_lat = v.act_lat;
    do step(); while (tick_i);
    pulses = 0; rst_ticks = 0; wait_ticks = 0; att_ticks = 0; act_cnt = 0;
    done_cnt = 0; dl_q = 0;
    start_i = 1'b1; run_on = 1;
    step();
    start_i = 1'b0;
    // R9: accepted start clears the verdict
    chk($sformatf("R9 v%0d ok cleared", idx), int'(link_ok_o), 0);
    chk($sformatf("R9 v%0d fail cleared", idx), int'(link_fail_o), 0);
    for (k = 0; k < 6000 && run_on; k++) begin
      step();
      start_i = (v.inj != 0 && k == 150); // R10 busy start
    end
    start_i = 1'b0;
    if (run_on) begin
      chk($sformatf("R8 v%0d watchdog", idx), 0, 1);
      run_on = 0;
    end
    hold_ok = link_ok_o; hold_fail = link_fail_o;
    // R4/R7 verdict
    chk($sformatf("R4 v%0d link_ok", idx), int'(link_ok_o), v.exp_ok);
    chk($sformatf("R7 v%0d link_fail", idx), int'(link_fail_o), 1 - v.exp_ok);
    chk($sformatf("R2 R5 v%0d reset pulses", idx), pulses, v.exp_pulses);
    chk($sformatf("R6 v%0d reset ticks", idx), rst_ticks, v.exp_pulses);
    chk($sformatf("R3 R10 v%0d wait ticks", idx), wait_ticks, v.exp_waits);
    repeat (10) step();
    chk($sformatf("R8 v%0d done count", idx), done_cnt, 1);
    chk($sformatf("R9 v%0d ok held", idx), int'(link_ok_o), int'(hold_ok));
    chk($sformatf("R9 v%0d fail held", idx), int'(link_fail_o), int'(hold_fail));
  endtask

  initial begin
    pulses = 0; rst_ticks = 0; wait_ticks = 0; att_ticks = 0; act_cnt = 0; done_cnt = 0;
    m_fail_att = 0; m_stuck_act = 0; m_dl_lat = 1; m_act_lat = 1;
    repeat (3) step();
    // R1 during reset
    chk("R1 rst during reset", int'(port_rst_o), 0);
    chk("R1 done during reset", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (5) step();
    chk("R1 rst after reset", int'(port_rst_o), 0);
    chk("R1 ok after reset", int'(link_ok_o), 0);
    chk("R1 fail after reset", int'(link_fail_o), 0);
    chk("R1 done after reset", done_cnt, 0);
    for (int i = 0; i < NV; i++) run(VECS[i], i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL R8 global watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule